// File: doc/BRIEF.md
# Pointer-Chasing Memory Copy Channel

This block is one memory-to-memory copy channel that masters a simple valid/ready bus. Software loads a source address, a destination address, a transfer count and a control word through a small write port, then pulses `start`. The channel then runs the whole job without further help and raises `done` when the count has been used up.

Two transfer modes exist. In the plain two-cycle mode, each unit of work reads one item at the source address and writes it to the destination address. In the pointer mode, the source register names a location that holds an address. The channel fetches that address as a full 32-bit word. It then reads the item stored there and writes the item to the destination. Pointer mode is built in only when the `INDIRECT_EN` parameter is set. An instance without it treats the mode bit as a plain copy request. The acknowledge strobe `dack` marks the bus cycle that reads the item being moved.

Top module: `ptr_dma_engine`

## Requirements
- R1: `cfg_we` with `cfg_sel` = 0, 1, 2, 3 loads the source address, the destination address, the count (low `CW` bits) and the control word. Control bit 0 requests pointer mode. Bit 1 enables source stepping. Bit 2 enables destination stepping. Bits 4:3 give the size: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit and 11 is 16-byte. Writes made while `busy` is high are dropped.
- R2: In plain mode, each unit of work is a read (`bus_write`=0) at the source address with the configured size. It is followed by a write (`bus_write`=1) of the read word to the destination address with the same size.
- R3: In pointer mode, each unit of work begins with a read at the source address with `bus_size`=10, whatever the configured size. The returned word is kept as a pointer.
- R4: In pointer mode, the second cycle reads at the kept pointer address with the configured size.
- R5: In pointer mode, the third cycle writes the word returned by the second read to the destination address with the configured size.
- R6: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_write`, `bus_wdata` and `bus_size` hold their values. A cycle completes on a clock edge where both are high.
- R7: `dack` is high exactly while the data-read cycle is presented. It is low during pointer fetches and writes.
- R8: A start is rejected in three cases: size 11, size 10 in pointer mode, or a count of zero. On rejection `err` goes high, no bus cycle is issued and `busy` stays low. An accepted start clears `err`.
- R9: When `INDIRECT_EN` is 0, control bit 0 is ignored and the job runs as plain copies.
- R10: The count drops by one after each write completes. After the write that takes it to zero, `busy` falls and `done` rises. `done` is cleared by the next start.
- R11: After each write, the source and destination addresses each advance by 1, 2 or 4 bytes (8, 16 or 32-bit size) when their stepping bit is set. Otherwise they stay fixed.
- R12: A `start` pulse while `busy` is high has no effect on the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | DW | Configuration write value |
| start | input | 1 | One-cycle job start request |
| bus_valid | output | 1 | Bus cycle presented |
| bus_write | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | DW | Byte address of the cycle |
| bus_size | output | 2 | Cycle size: 00 byte, 01 halfword, 10 word |
| bus_wdata | output | DW | Write data |
| bus_ready | input | 1 | Slave accepts the cycle at this edge |
| bus_rdata | input | DW | Read data, valid with `bus_ready` on reads |
| dack | output | 1 | Data-read acknowledge strobe |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished; held until the next start |
| err | output | 1 | Last start was rejected |

## Verification
The assertions assume a slave that may hold `bus_ready` low for any number of cycles, and that nothing changes the configuration mid-job except writes the channel drops. The stimulus drives `bus_ready` from a wait-state counter and drives `bus_rdata` from a fixed function of `bus_addr`. This lets returned pointers land on arbitrary addresses and still be predicted. Control writes and extra start pulses during a job are issued on purpose, to show that the lock leaves the sequence intact.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_QUAD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PTR  = 2'd1,
        PH_RD   = 2'd2,
        PH_WR   = 2'd3
    } phase_e;

    // control word, bit 0 at the right
    typedef struct packed {
        xfer_size_e size;
        logic       dst_inc;
        logic       src_inc;
        logic       ind_req;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    function automatic logic [4:0] size_bytes(xfer_size_e s);
        case (s)
            SZ_BYTE: return 5'd1;
            SZ_HALF: return 5'd2;
            SZ_WORD: return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_eng_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          lock,
    input  logic          step,
    output logic [DW-1:0] src_addr,
    output logic [DW-1:0] dst_addr,
    output logic [CW-1:0] xfer_cnt,
    output chan_ctrl_t    ctrl
);

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [CW-1:0] cnt;
        chan_ctrl_t    ctrl;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [DW-1:0] stride;
    logic          cfg_unused;

    assign cfg_unused = ^cfg_wdata[DW-1:CTRL_W];
    assign stride     = {{(DW-5){1'b0}}, size_bytes(regs_q.ctrl.size)};

    always_comb begin
        regs_d = regs_q;
        if (cfg_we && !lock) begin
            case (cfg_sel)
                SEL_SRC:  regs_d.src  = cfg_wdata;
                SEL_DST:  regs_d.dst  = cfg_wdata;
                SEL_CNT:  regs_d.cnt  = cfg_wdata[CW-1:0];
                default:  regs_d.ctrl = chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            endcase
        end
        if (step) begin
            regs_d.cnt = regs_q.cnt - CW'(1);
            if (regs_q.ctrl.src_inc) regs_d.src = regs_q.src + stride;
            if (regs_q.ctrl.dst_inc) regs_d.dst = regs_q.dst + stride;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign src_addr = regs_q.src;
    assign dst_addr = regs_q.dst;
    assign xfer_cnt = regs_q.cnt;
    assign ctrl     = regs_q.ctrl;

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (xfer_cnt == $past(xfer_cnt) - CW'(1)));

    // R1
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lock && !step) |=> (src_addr == $past(src_addr) && dst_addr == $past(dst_addr)
                                       && xfer_cnt == $past(xfer_cnt) && ctrl == $past(ctrl)));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_eng_pkg::*;
#(
    parameter int DW          = 32,
    parameter int CW          = 16,
    parameter bit INDIRECT_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] src_addr,
    input  logic [DW-1:0] dst_addr,
    input  logic [CW-1:0] xfer_cnt,
    input  chan_ctrl_t    ctrl,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [DW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    output logic          dack,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          step
);

    typedef struct packed {
        phase_e        ph;
        logic          ind;
        logic [DW-1:0] ptr;
        logic [DW-1:0] data;
        logic          done;
        logic          err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ind_sel;
    logic bad_cfg;
    logic hs;

    assign ind_sel = INDIRECT_EN && ctrl.ind_req;
    assign bad_cfg = (ctrl.size == SZ_QUAD)
                   || (ind_sel && ctrl.size == SZ_WORD)
                   || (xfer_cnt == '0);
    assign hs      = bus_valid && bus_ready;

    always_comb begin
        seq_d = seq_q;
        step  = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    seq_d.done = 1'b0;
                    if (bad_cfg) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.err = 1'b0;
                        seq_d.ind = ind_sel;
                        seq_d.ph  = ind_sel ? PH_PTR : PH_RD;
                    end
                end
            end
            PH_PTR: begin
                if (hs) begin
                    seq_d.ptr = bus_rdata;
                    seq_d.ph  = PH_RD;
                end
            end
            PH_RD: begin
                if (hs) begin
                    seq_d.data = bus_rdata;
                    seq_d.ph   = PH_WR;
                end
            end
            default: begin
                if (hs) begin
                    step = 1'b1;
                    if (xfer_cnt == CW'(1)) begin
                        seq_d.ph   = PH_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.ph = seq_q.ind ? PH_PTR : PH_RD;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    always_comb begin
        bus_valid = (seq_q.ph != PH_IDLE);
        bus_write = (seq_q.ph == PH_WR);
        bus_size  = (seq_q.ph == PH_PTR) ? SZ_WORD : ctrl.size;
        bus_wdata = seq_q.data;
        case (seq_q.ph)
            PH_PTR:  bus_addr = src_addr;
            PH_RD:   bus_addr = seq_q.ind ? seq_q.ptr : src_addr;
            PH_WR:   bus_addr = dst_addr;
            default: bus_addr = '0;
        endcase
    end

    assign dack = (seq_q.ph == PH_RD);
    assign busy = bus_valid;
    assign done = seq_q.done;
    assign err  = seq_q.err;

    // R6
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)
                                       && $stable(bus_wdata) && $stable(bus_size)));

    // R8
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bad_cfg) |=> (!bus_valid && err));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && dack) |=> (bus_write && bus_wdata == $past(bus_rdata)));

    generate
        if (!INDIRECT_EN) begin : g_plain_only
            // R9
            no_ptr_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_valid && !bus_write) |-> dack);
        end
    endgenerate

endmodule

// File: rtl/ptr_dma_engine.sv
module ptr_dma_engine
    import dma_eng_pkg::*;
#(
    parameter int DW          = 32,
    parameter int CW          = 16,
    parameter bit INDIRECT_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          start,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [DW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic          dack,
    output logic          busy,
    output logic          done,
    output logic          err
);

    logic [DW-1:0] src_addr;
    logic [DW-1:0] dst_addr;
    logic [CW-1:0] xfer_cnt;
    chan_ctrl_t    ctrl;
    logic          step;

    dma_chan_regs #(.DW(DW), .CW(CW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .lock     (busy),
        .step     (step),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .xfer_cnt (xfer_cnt),
        .ctrl     (ctrl)
    );

    dma_xfer_seq #(.DW(DW), .CW(CW), .INDIRECT_EN(INDIRECT_EN)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .xfer_cnt (xfer_cnt),
        .ctrl     (ctrl),
        .bus_ready(bus_ready),
        .bus_rdata(bus_rdata),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .dack     (dack),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .step     (step)
    );

    // R3
    ptr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !dack) |-> (bus_size == SZ_WORD));

    // R7
    dack_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> (bus_valid && !bus_write));

endmodule

// File: tb/ptr_dma_engine_tb_top.sv
module ptr_dma_engine_tb_top;

    localparam int DW = 32;
    localparam int CW = 16;

    typedef struct packed {
        logic [4:0]  ctrl;
        logic [31:0] src;
        logic [31:0] dst;
        logic [3:0]  cnt;
        logic [1:0]  waits;
    } vec_t;

    // ctrl = {size[1:0], dst_inc, src_inc, ind_req}
    localparam vec_t VECS [0:5] = '{
        {5'h06, 32'h0000_1000, 32'h0000_2000, 4'd3, 2'd0},
        {5'h10, 32'h0000_1100, 32'h0000_2100, 4'd2, 2'd2},
        {5'h0B, 32'h0000_1200, 32'h0000_2200, 4'd2, 2'd1},
        {5'h05, 32'h0000_1300, 32'h0000_2300, 4'd3, 2'd0},
        {5'h0E, 32'h0000_1400, 32'h0000_2400, 4'd1, 2'd3},
        {5'h0F, 32'h0000_1500, 32'h0000_2500, 4'd1, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          start = 1'b0;
    logic          start_nx = 1'b0;
    logic          bus_valid, bus_write, dack, busy, done, err;
    logic [DW-1:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]    bus_size;
    logic          bus_ready = 1'b0;
    logic          nx_valid, nx_write, nx_dack, nx_busy, nx_done, nx_err;
    logic [DW-1:0] nx_addr, nx_wdata, nx_rdata;
    logic [1:0]    nx_size;

    int checks = 0;
    int errors = 0;

    // bench-side bus log
    int            cur_wait = 0;
    int            wcnt = 0;
    int            log_n = 0;
    int            hold_bad = 0;
    logic          hold_v = 1'b0;
    logic [DW-1:0] h_a, h_d;
    logic          h_w;
    logic [1:0]    h_s;
    logic          log_w [0:63];
    logic [DW-1:0] log_a [0:63];
    logic [1:0]    log_s [0:63];
    logic [DW-1:0] log_d [0:63];
    logic          log_k [0:63];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rd_fn(logic [31:0] a);
        return {a[15:0] ^ 16'h3C3C, ~a[15:0]};
    endfunction

    assign bus_rdata = rd_fn(bus_addr);
    assign nx_rdata  = rd_fn(nx_addr);

    ptr_dma_engine #(.DW(DW), .CW(CW), .INDIRECT_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .dack(dack), .busy(busy), .done(done), .err(err)
    );

    ptr_dma_engine #(.DW(DW), .CW(CW), .INDIRECT_EN(1'b0)) dut_nx_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start_nx), .bus_valid(nx_valid), .bus_write(nx_write), .bus_addr(nx_addr),
        .bus_size(nx_size), .bus_wdata(nx_wdata), .bus_ready(1'b1), .bus_rdata(nx_rdata),
        .dack(nx_dack), .busy(nx_busy), .done(nx_done), .err(nx_err)
    );

    // slave model: decides ready at the falling edge, logs accepted cycles
    always @(negedge clk) begin
        if (bus_valid) begin
            if (hold_v && (bus_addr != h_a || bus_write != h_w || bus_wdata != h_d || bus_size != h_s))
                hold_bad++;
            if (wcnt >= cur_wait) begin
                bus_ready = 1'b1;
                if (log_n < 64) begin
                    log_w[log_n] = bus_write;
                    log_a[log_n] = bus_addr;
                    log_s[log_n] = bus_size;
                    log_d[log_n] = bus_wdata;
                    log_k[log_n] = dack;
                end
                log_n++;
                wcnt   = 0;
                hold_v = 1'b0;
            end else begin
                bus_ready = 1'b0;
                wcnt++;
                hold_v = 1'b1;
                h_a = bus_addr; h_d = bus_wdata; h_w = bus_write; h_s = bus_size;
            end
        end else begin
            bus_ready = 1'b0;
            wcnt      = 0;
            hold_v    = 1'b0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic configure(logic [4:0] c, logic [31:0] s, logic [31:0] d, logic [15:0] n);
        cfg_write(2'd0, s);
        cfg_write(2'd1, d);
        cfg_write(2'd2, {16'h0, n});
        cfg_write(2'd3, {27'h0, c});
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic chk_entry(int i, logic w, logic [31:0] a, logic [1:0] s, logic [31:0] d, logic k, string tag);
        chk({tag, " cycle kind"}, {31'h0, log_w[i]}, {31'h0, w});
        chk({tag, " address"}, log_a[i], a);
        chk({tag, " size"}, {30'h0, log_s[i]}, {30'h0, s});
        chk({tag, " R7 dack"}, {31'h0, log_k[i]}, {31'h0, k});
        if (w) chk({tag, " write data"}, log_d[i], d);
    endtask

    task automatic run_vec(vec_t v);
        int          bytes;
        int          idx;
        logic [31:0] s, d, p;
        logic        ind;
        bytes = (v.ctrl[4:3] == 2'b00) ? 1 : (v.ctrl[4:3] == 2'b01) ? 2 : 4;
        ind   = v.ctrl[0];
        configure(v.ctrl, v.src, v.dst, {12'h0, v.cnt});
        cur_wait = int'(v.waits);
        log_n    = 0;
        hold_bad = 0;
        pulse_start();
        chk("R10 done cleared by start", {31'h0, done}, 32'h0);
        wait_done();
        chk("R10 done after last write", {31'h0, done}, 32'h1);
        chk("R10 busy low at end", {31'h0, busy}, 32'h0);
        chk("R8 err clear on good start", {31'h0, err}, 32'h0);
        chk("R6 held while not ready", hold_bad, 0);
        chk("cycle count", log_n, ind ? 3 * int'(v.cnt) : 2 * int'(v.cnt));
        idx = 0;
        for (int k = 0; k < int'(v.cnt); k++) begin
            // R11 stepping
            s = v.src + (v.ctrl[1] ? 32'(k * bytes) : 32'h0);
            d = v.dst + (v.ctrl[2] ? 32'(k * bytes) : 32'h0);
            if (ind) begin
                p = rd_fn(s);
                chk_entry(idx,     1'b0, s, 2'b10,       32'h0,    1'b0, "R3 pointer fetch");
                chk_entry(idx + 1, 1'b0, p, v.ctrl[4:3], 32'h0,    1'b1, "R4 read via pointer");
                chk_entry(idx + 2, 1'b1, d, v.ctrl[4:3], rd_fn(p), 1'b0, "R5 R11 write");
                idx += 3;
            end else begin
                chk_entry(idx,     1'b0, s, v.ctrl[4:3], 32'h0,    1'b1, "R2 read");
                chk_entry(idx + 1, 1'b1, d, v.ctrl[4:3], rd_fn(s), 1'b0, "R2 R11 write");
                idx += 2;
            end
        end
    endtask

    task automatic bad_start(logic [4:0] c, logic [15:0] n, string tag);
        configure(c, 32'h0000_3000, 32'h0000_4000, n);
        log_n = 0;
        pulse_start();
        chk({tag, " err"}, {31'h0, err}, 32'h1);
        chk({tag, " busy"}, {31'h0, busy}, 32'h0);
        repeat (3) @(negedge clk);
        chk({tag, " no bus cycle"}, log_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("reset bus_valid", {31'h0, bus_valid}, 32'h0);
        chk("reset busy", {31'h0, busy}, 32'h0);
        chk("reset done", {31'h0, done}, 32'h0);
        chk("reset err", {31'h0, err}, 32'h0);
        chk("reset R7 dack", {31'h0, dack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2..R7, R10, R11 from the vector table
        for (int i = 0; i < 6; i++) run_vec(VECS[i]);

        // R8 rejected starts
        bad_start(5'h18, 16'd2, "R8 size 11");
        bad_start(5'h11, 16'd2, "R8 word in pointer mode");
        bad_start(5'h00, 16'd0, "R8 zero count");
        run_vec(VECS[0]);

        // R12 and R1: start and config writes during a job
        configure(5'h00, 32'h0000_0200, 32'h0000_0300, 16'd2);
        cur_wait = 3;
        log_n    = 0;
        pulse_start();
        cfg_write(2'd0, 32'h0000_0777);
        pulse_start();
        wait_done();
        chk("R12 start while busy ignored", log_n, 4);
        chk("R12 first read address", log_a[0], 32'h0000_0200);
        chk("R12 second read address", log_a[2], 32'h0000_0200);
        log_n = 0;
        pulse_start();
        wait_done();
        chk("R1 write during busy dropped", log_a[0], 32'h0000_0200);
        cur_wait = 0;

        // R9 channel without pointer mode
        configure(5'h09, 32'h0000_0100, 32'h0000_0180, 16'd1);
        @(negedge clk); start_nx = 1'b1;
        @(negedge clk); start_nx = 1'b0;
        chk("R9 first cycle is data read", {31'h0, nx_valid & ~nx_write & nx_dack}, 32'h1);
        chk("R9 read address", nx_addr, 32'h0000_0100);
        chk("R9 read size", {30'h0, nx_size}, 32'h1);
        @(negedge clk);
        chk("R9 write cycle", {31'h0, nx_write}, 32'h1);
        chk("R9 write data", nx_wdata, rd_fn(32'h0000_0100));
        @(negedge clk);
        chk("R9 done", {31'h0, nx_done}, 32'h1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule